// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a Clause 22 MDIO master that software drives through three registers on a simple memory-mapped bus. One write to the command register carries everything a management transaction needs: the operation, the PHY address, the PHY register address and, for a write, the sixteen data bits. The block then runs the serial frame on MDC and MDIO, shows a busy flag in the status register while the frame is in flight, and places the result of a read, with a two-bit error code, in the data register.

MDC comes from the system clock through a parameterised divider and runs only while a frame is active. The master changes MDIO on the falling edge of MDC and samples the PHY on the rising edge. On a read it releases the line for the turnaround and the data phase. If the PHY does not pull the line low in the second turnaround bit, the read is flagged as failed. Software is expected to poll busy before it issues a command and again before it reads the result. The block refuses commands while busy is set.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, reads of the status (offset 0x0), command (0x8) and data (0xC) registers return zero, and mdc and mdio_oe are low. Read data appears on bus_rdata one cycle after bus_rd. Reads of the command register and of unmapped offsets return zero.
- R2: A write to offset 0x8 is accepted when bit 31 (valid) is set and exactly one of bit 1 (write) and bit 2 (read) is set. Status bit 3 (busy) is then high from the next cycle for exactly 128*DIV_HALF cycles. All other status bits read zero.
- R3: A command without bit 31 set, or with both or neither of bits 1 and 2 set, is ignored: no MDC edge occurs and busy stays low. Bits 0 and 3 have no effect on an accepted command.
- R4: A command written while busy is set is ignored. The frame in flight is unchanged and no second frame follows.
- R5: A frame is 64 bits sent MSB first: 32 ones, start 01, opcode (10 for read, 01 for write), PHY address (command bits 29:25), register address (bits 24:20), turnaround 10 for a write, then 16 data bits (command bits 19:4 for a write).
- R6: mdc is low while idle and has a period of 2*DIV_HALF system cycles while busy. mdio_o changes only while mdc is low or on its falling edge, and never on the rising edge.
- R7: For a write, mdio_oe is high for all 64 bits. For a read, it is high for the first 46 bits and low for the turnaround and data bits.
- R8: After a read, the data register holds the 16 bits the PHY drove in bits 15:0, MSB first, and an error code in bits 17:16. The code is 00 when the PHY drove 0 in the second turnaround bit and 10 otherwise. Bits 31:18 read zero.
- R9: A write operation leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad |
| mdio_i | input | 1 | Serial data from the MDIO pad |

## Verification
The bench sweeps PHY and register addresses across all-zero, all-one, alternating and single-bit-end patterns. These patterns show whether the address fields are swapped, shifted or bit-reversed. Write data and PHY read responses use 0x0000, 0xFFFF, 0xA5C3 and 0x8001, which catch lost or reordered edge bits in the data phase. Reads run once with a responding PHY and once with a silent one, which tells the error code apart from the data. Malformed commands, commands issued while busy, and the scan bits are each tried to confirm that they cannot start a frame or alter one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_STATUS   = 'h0;
  localparam int REG_CMD      = 'h8;
  localparam int REG_DATA     = 'hC;
  localparam int STAT_BUSY    = 3;
  localparam int CMD_VALID    = 31;
  localparam int CMD_OP_WR    = 1;
  localparam int CMD_OP_RD    = 2;
  localparam int FRAME_LEN    = 64;
  localparam int RD_DRIVE_LEN = 46;
  localparam int TA2_IDX      = 47;
  localparam int DATA_IDX     = 48;
  localparam logic [1:0] ERR_NONE = 2'b00;
  localparam logic [1:0] ERR_TA   = 2'b10;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_cmd_t;

  function automatic logic [FRAME_LEN-1:0] make_frame(mdio_cmd_t c);
    return {32'hFFFF_FFFF, 2'b01, (c.rd ? 2'b10 : 2'b01), c.phy, c.regad,
            (c.rd ? 2'b11 : 2'b10), (c.rd ? 16'hFFFF : c.wdata)};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap      = run && (cnt == LAST);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (cnt == LAST) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data,
  output logic        ta_err
);
  localparam int BW = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shreg;
  logic [BW-1:0]        bitcnt;
  logic                 is_rd;

  assign mdio_o = shreg[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      bitcnt  <= '0;
      is_rd   <= 1'b0;
      mdio_oe <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
      ta_err  <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        shreg   <= make_frame(cmd);
        bitcnt  <= '0;
        is_rd   <= cmd.rd;
        mdio_oe <= 1'b1;
        ta_err  <= 1'b0;
      end else if (busy) begin
        if (rise_tick && is_rd) begin
          if (int'(bitcnt) == TA2_IDX) ta_err <= mdio_i;
          if (int'(bitcnt) >= DATA_IDX) rd_data <= {rd_data[14:0], mdio_i};
        end
        if (fall_tick) begin
          if (int'(bitcnt) == FRAME_LEN - 1) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
            bitcnt  <= '0;
            rd_done <= is_rd;
          end else begin
            bitcnt  <= bitcnt + 1'b1;
            shreg   <= {shreg[FRAME_LEN-2:0], 1'b1};
            mdio_oe <= !(is_rd && (int'(bitcnt) + 1 >= RD_DRIVE_LEN));
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(REG_CMD);
  localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(REG_DATA);

  logic        busy_w, rise_w, fall_w, accept;
  logic        rd_done_w, ta_err_w;
  logic [15:0] rd_data_w;
  logic [17:0] data_q;
  mdio_cmd_t   cmd_w;
  logic        unused_bits;

  assign unused_bits = ^{bus_wdata[30], bus_wdata[3], bus_wdata[0]};

  assign cmd_w.rd    = bus_wdata[CMD_OP_RD];
  assign cmd_w.phy   = bus_wdata[29:25];
  assign cmd_w.regad = bus_wdata[24:20];
  assign cmd_w.wdata = bus_wdata[19:4];

  assign accept = bus_wr && (bus_addr == A_CMD) && bus_wdata[CMD_VALID] &&
                  (bus_wdata[CMD_OP_WR] ^ bus_wdata[CMD_OP_RD]) && !busy_w;

  mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy_w),
    .mdc(mdc), .rise_tick(rise_w), .fall_tick(fall_w)
  );

  mdio_frame u_frame (
    .clk(clk), .rst(rst), .start(accept), .cmd(cmd_w),
    .rise_tick(rise_w), .fall_tick(fall_w), .mdio_i(mdio_i),
    .busy(busy_w), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done_w), .rd_data(rd_data_w), .ta_err(ta_err_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (rd_done_w) begin
      data_q <= {(ta_err_w ? ERR_TA : ERR_NONE), rd_data_w};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_STATUS: bus_rdata <= 32'(busy_w) << STAT_BUSY;
        A_DATA:   bus_rdata <= {14'b0, data_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy_w,
  input logic [17:0]       data_q
);
  a_r6_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !busy_w |-> !mdc);

  a_r6_no_change_on_rise: assert property (@(posedge clk) disable iff (rst)
    mdc |-> $stable(mdio_o));

  a_r2_end_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_w) |-> $fell(mdc));

  a_r3_start_needs_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_w) |-> $past(bus_wr && bus_addr == ADDR_W'(8) && bus_wdata[31]));

  a_r7_oe_only_busy: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy_w);

  a_r8_err_code: assert property (@(posedge clk) disable iff (rst)
    !data_q[16]);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy_w(busy_w), .data_q(data_q)
);

// File: tb/tb_mdio_cmd_ctrl.sv
module tb_mdio_cmd_ctrl;
  localparam int H = 2;
  localparam int AW = 4;

  logic clk = 0, rst = 1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_drv = 1'b1;

  int n_tests = 0, n_fail = 0, cyc = 0;

  logic [15:0] resp_data = '0;
  logic        resp_ta_ok = 1'b1;
  logic [63:0] cap_o = '0, cap_oe = '0;
  logic [5:0]  rcnt = '0;
  int          rise_total = 0;
  logic        mdc_q = 1'b0;
  logic [31:0] last_read = '0;

  always #4 clk = ~clk;

  mdio_cmd_ctrl #(.DIV_HALF(H), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(phy_drv)
  );

  function automatic logic phy_bit(int k, logic ta_ok, logic [15:0] d);
    if (k == 47) return !ta_ok;
    if (k >= 48) return d[63 - k];
    return 1'b1;
  endfunction

  // PHY model: capture at MDC rise, present next bit after MDC fall
  always @(negedge clk) begin
    if (mdc && !mdc_q) begin
      cap_o[rcnt]  <= mdio_o;
      cap_oe[rcnt] <= mdio_oe;
      rcnt         <= rcnt + 1'b1;
      rise_total   <= rise_total + 1;
    end
    if (!mdc && mdc_q) phy_drv <= phy_bit(int'(rcnt), resp_ta_ok, resp_data);
    mdc_q <= mdc;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_tests = n_tests + 1;
      n_fail  = n_fail + 1;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = AW'(a); bus_rd = 1;
    @(posedge clk); #1;
    bus_rd = 0; d = bus_rdata;
  endtask

  // count busy cycles by continuous status polling
  task automatic count_busy(output int n);
    n = 0;
    bus_addr = AW'(0); bus_rd = 1;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (bus_rdata[3]) n++;
      else if (i > 0) break;
    end
    bus_rd = 0;
  endtask

  task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] resp,
                         input bit ta_ok, input bit inj, input bit scanbits);
    logic [31:0] cmd, v;
    logic [63:0] exp, mask;
    int n, r0;
    resp_data  = resp;
    resp_ta_ok = ta_ok;
    r0 = rise_total;
    cmd = {1'b1, 1'b0, phy, rg, wd, 1'b0, rd, !rd, 1'b0};
    if (scanbits) cmd = cmd | 32'h9;
    bus_write('h8, cmd);
    if (inj) bus_write('h8, {1'b1, 1'b0, ~phy, ~rg, ~wd, 4'b0100});
    count_busy(n);
    chk(n == 128*H - (inj ? 2 : 0), "R2 busy length", n, 128*H - (inj ? 2 : 0));
    for (int k = 0; k < 64; k++) begin
      logic b;
      if (k < 32) b = 1;
      else if (k == 32) b = 0;
      else if (k == 33) b = 1;
      else if (k == 34) b = rd;
      else if (k == 35) b = !rd;
      else if (k < 41) b = phy[40 - k];
      else if (k < 46) b = rg[45 - k];
      else if (k == 46) b = 1;
      else if (k == 47) b = 0;
      else b = wd[63 - k];
      exp[k]  = b;
      mask[k] = rd ? (k < 46) : 1'b1;
    end
    chk(cap_oe == mask, "R7 output enable", cap_oe, mask);
    chk((cap_o & mask) == (exp & mask), "R5 frame bits", cap_o & mask, exp & mask);
    chk(rise_total - r0 == 64, inj ? "R4 one frame only" : "R6 mdc edges",
        rise_total - r0, 64);
    repeat (4*H) @(posedge clk);
    #1;
    chk(mdc == 0 && rise_total - r0 == 64, "R4 R6 idle after frame", mdc, 0);
    bus_read('hC, v);
    if (rd) begin
      logic [31:0] e;
      e = {14'b0, (ta_ok ? 2'b00 : 2'b10), resp};
      chk(v == e, "R8 read result", v, e);
      last_read = e;
    end else begin
      chk(v == last_read, "R9 data kept on write", v, last_read);
    end
  endtask

  task automatic try_ignored(input logic [31:0] cmd, input string req);
    logic [31:0] v;
    int r0;
    r0 = rise_total;
    bus_write('h8, cmd);
    repeat (6*H) @(posedge clk);
    bus_read('h0, v);
    chk(v == 0 && rise_total == r0, req, {v, 32'(rise_total - r0)}, 0);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #0;
    chk(mdc == 0 && mdio_oe == 0, "R1 pins after reset", {mdc, mdio_oe}, 0);
    bus_read('h0, v); chk(v == 0, "R1 status reset", v, 0);
    bus_read('h8, v); chk(v == 0, "R1 command reads zero", v, 0);
    bus_read('hC, v); chk(v == 0, "R1 data reset", v, 0);
    bus_read('h4, v); chk(v == 0, "R1 unmapped zero", v, 0);

    try_ignored(32'h7FFF_FFF4, "R3 no valid bit");
    try_ignored(32'h8123_4560, "R3 no op bit");
    try_ignored(32'h8123_4566, "R3 both op bits");
    try_ignored(32'h8123_4569, "R3 scan bits only");

    run_cmd(1, 5'h00, 5'h00, 16'h0, 16'hA5C3, 1, 0, 0);
    run_cmd(0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 1, 0, 0);
    run_cmd(0, 5'h15, 5'h0A, 16'h8001, 16'h0, 1, 0, 1);
    run_cmd(1, 5'h01, 5'h10, 16'h0, 16'h8001, 1, 0, 0);
    run_cmd(1, 5'h0A, 5'h15, 16'h0, 16'hFFFF, 0, 0, 0);
    run_cmd(1, 5'h10, 5'h01, 16'h0, 16'h0000, 1, 1, 0);
    run_cmd(0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1, 1, 0);
    run_cmd(0, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 1, 0, 0);
    run_cmd(1, 5'h1F, 5'h1F, 16'h0, 16'h5A3C, 1, 0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule